// File: doc/BRIEF.md
# Cycle Counter with One-Shot Timer Compare

This block keeps a free-running cycle count split into a low and a high word, and offers it to the control-register read path of a processor core. The low word advances on every clock; the high word advances whenever the low word rolls over. Both words are read-only. Three user-level read addresses mirror the low word for cycle and time, and return zero for the retired-instruction count, which this block does not keep.

Next to the counter sits a software-writable compare register. Writing it arms a one-shot comparator. When the low counter word equals the compare value while armed, the block raises the machine timer interrupt-pending output and disarms, so one write gives at most one event. A later write to the compare register clears the pending output and arms the comparator again. After reset the comparator stays disarmed, so a compare value of zero does not fire by itself.

The read port is combinational on the registered state: the data for an address shows up in the same cycle that the address is presented. The write port accepts one register write per cycle, and only the compare address has any effect.

Top module: `cycle_timer_csr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counter words, the compare register and `mtip_o` go to zero and the comparator goes to the disarmed state.
- R2: Out of reset, the low counter word increases by one on every clock edge and wraps from all-ones to zero (modulo 2^WORD_W).
- R3: The high counter word increases by one on exactly the edges at which the low word wraps from all-ones to zero, and holds on every other edge.
- R4: A read of address 0xB00 returns the low word and a read of 0xB80 returns the high word, both zero-extended to 32 bits, in the same cycle as the address.
- R5: Reads of 0xC00 and 0xC01 both return the zero-extended low word. A read of 0xC02 returns zero.
- R6: Address 0x7C0 holds a 32-bit compare value. A write with `wr_en_i` high stores all 32 data bits at the clock edge, and reads of 0x7C0 return the stored value.
- R7: A write to any address other than 0x7C0, the counter addresses included, changes neither counter word nor the compare register.
- R8: When the comparator is armed, no compare write is taking place, and the compare value equals the zero-extended low word at a clock edge, `mtip_o` is 1 after that edge and the comparator is disarmed.
- R9: Once set, `mtip_o` stays at 1 until the next compare write or reset, even when the low word later matches again.
- R10: A write to 0x7C0 clears `mtip_o` and arms the comparator at that edge. The write takes priority over a match in the same cycle.
- R11: A comparator that has never been armed since reset does not raise `mtip_o`, even when the low word wraps past the reset compare value of zero.
- R12: A read of any address other than 0xB00, 0xB80, 0xC00, 0xC01, 0xC02 and 0x7C0 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr_i | input | 12 | Register read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i`, combinational |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | 32 | Register write data |
| mtip_o | output | 1 | Machine timer interrupt pending |

## Verification
The bound checker checks the counter stepping and the carry into the high word on every edge. It also checks that the compare register holds except on a compare write, and checks the arming, firing, disarming, sticky-pending and write-wins rules of the comparator on every cycle. The read decode, the zero result for unmapped and instret addresses, and the fact that writes to the counter addresses have no effect can only be seen through the bench scenarios. Those scenarios compare each read against an independent model. The same holds for the disarmed state across a wrap through zero after reset, and for a compare write that lands on the matching cycle.

// File: rtl/cyc_csr_pkg.sv
// Package: shared constants and types of the cycle counter / timer compare block.
// Assumes 12-bit register addresses and a 32-bit register data path.
package cyc_csr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CSR_ADDR_W = 12;
    localparam int unsigned CSR_DATA_W = 32;

    typedef logic [CSR_ADDR_W-1:0] csr_addr_t;

    // Address map; software depends on these values.
    localparam csr_addr_t ADDR_CNT_LO  = 12'hB00;
    localparam csr_addr_t ADDR_CNT_HI  = 12'hB80;
    localparam csr_addr_t ADDR_U_CYCLE = 12'hC00;
    localparam csr_addr_t ADDR_U_TIME  = 12'hC01;
    localparam csr_addr_t ADDR_U_INSTR = 12'hC02;
    localparam csr_addr_t ADDR_CMP     = 12'h7C0;

    // Read source selected by the address decoder.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_LO   = 3'd1,
        SRC_HI   = 3'd2,
        SRC_CMP  = 3'd3,
        SRC_ZERO = 3'd4
    } rd_src_e;
endpackage

// File: rtl/cyc_counter.sv
// Module: cyc_counter
// Two-word free-running cycle counter. The low word advances every clock,
// the high word advances on the edge at which the low word wraps.
// Assumes: synchronous active-low reset; no write access to either word.
module cyc_counter #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic              lo_wrap;

    // Carry out of the low word: it is all-ones and wraps on this edge.
    assign lo_wrap = &lo_q;

    // Low word: plus one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else begin
            lo_q <= lo_q + WORD_W'(1);
        end
    end

    // High word: plus one on the low-word carry only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (lo_wrap) begin
            hi_q <= hi_q + WORD_W'(1);
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/cyc_compare.sv
// Module: cyc_compare
// One-shot timer comparator. A write stores the compare value, arms and
// clears the pending flag. While armed, equality with the zero-extended
// low counter word sets pending and disarms. A write wins over a match.
// Assumes: WORD_W <= DATA_W; synchronous active-low reset, leaves disarmed.
module cyc_compare #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [WORD_W-1:0] cnt_lo_i,
    output logic [DATA_W-1:0] cmp_o,
    output logic              armed_o,
    output logic              pend_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DATA_W-1:0] cmp_q;
    logic              armed_q;
    logic              pend_q;
    logic              hit;

    // Equality of compare value and counter, counter zero-extended.
    assign hit = armed_q && (cmp_q == DATA_W'(cnt_lo_i));

    // Compare value: loaded by software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_hit_i) begin
            cmp_q <= wr_data_i;
        end
    end

    // Arm and pending flags: write re-arms and clears, a hit fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (wr_hit_i) begin
            armed_q <= 1'b1;
            pend_q  <= 1'b0;
        end else if (hit) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b1;
        end
    end

    assign cmp_o   = cmp_q;
    assign armed_o = armed_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/cyc_rd_decode.sv
// Module: cyc_rd_decode
// Maps a register read address onto the source that supplies its data.
// Purely combinational. Assumes the address map in cyc_csr_pkg.
module cyc_rd_decode
    import cyc_csr_pkg::*;
(
    input  csr_addr_t addr_i,
    output rd_src_e   src_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // Address to source lookup; unknown addresses read as none.
    always_comb begin
        unique case (addr_i)
            ADDR_CNT_LO, ADDR_U_CYCLE, ADDR_U_TIME: src_o = SRC_LO;
            ADDR_CNT_HI:                            src_o = SRC_HI;
            ADDR_CMP:                               src_o = SRC_CMP;
            ADDR_U_INSTR:                           src_o = SRC_ZERO;
            default:                                src_o = SRC_NONE;
        endcase
    end
endmodule

// File: rtl/cycle_timer_csr.sv
// Module: cycle_timer_csr (top)
// Cycle counter registers with a one-shot timer compare and the
// timer-pending output. Reads are combinational on registered state,
// writes take effect at the clock edge. Only the compare address is writable.
// Assumes: WORD_W <= 32; synchronous active-low reset.
module cycle_timer_csr
    import cyc_csr_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] rd_addr_i,
    output logic [31:0] rd_data_o,
    input  logic        wr_en_i,
    input  logic [11:0] wr_addr_i,
    input  logic [31:0] wr_data_i,
    output logic        mtip_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned XLEN = CSR_DATA_W;

    logic [WORD_W-1:0] cnt_lo;
    logic [WORD_W-1:0] cnt_hi;
    logic [XLEN-1:0]   cmp_val;
    logic              armed;
    logic              cmp_wr;
    rd_src_e           rd_src;

    // Write decode: only the compare register accepts writes.
    assign cmp_wr = wr_en_i && (wr_addr_i == ADDR_CMP);

    cyc_counter #(
        .WORD_W (WORD_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_o  (cnt_lo),
        .hi_o  (cnt_hi)
    );

    cyc_compare #(
        .WORD_W (WORD_W),
        .DATA_W (XLEN)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit_i  (cmp_wr),
        .wr_data_i (wr_data_i),
        .cnt_lo_i  (cnt_lo),
        .cmp_o     (cmp_val),
        .armed_o   (armed),
        .pend_o    (mtip_o)
    );

    cyc_rd_decode u_dec (
        .addr_i (rd_addr_i),
        .src_o  (rd_src)
    );

    // Read data mux, counter words zero-extended.
    always_comb begin
        unique case (rd_src)
            SRC_LO:   rd_data_o = XLEN'(cnt_lo);
            SRC_HI:   rd_data_o = XLEN'(cnt_hi);
            SRC_CMP:  rd_data_o = cmp_val;
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/cyc_timer_chk.sv
// Module: cyc_timer_chk
// Checker for cycle_timer_csr, bound to every instance of the top.
// Relates counter, compare and pending state across clock edges.
module cyc_timer_chk
    import cyc_csr_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned XLEN   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [11:0]       wr_addr_i,
    input logic              mtip_o,
    input logic [WORD_W-1:0] cnt_lo,
    input logic [WORD_W-1:0] cnt_hi,
    input logic [XLEN-1:0]   cmp_val,
    input logic              armed
);
    timeunit 1ns;
    timeprecision 1ps;

    logic wr_cmp;
    assign wr_cmp = wr_en_i && (wr_addr_i == ADDR_CMP);

    // R2
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_lo == WORD_W'($past(cnt_lo) + WORD_W'(1)));

    // R3
    hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (&$past(cnt_lo)) |-> cnt_hi == WORD_W'($past(cnt_hi) + WORD_W'(1)));

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !(&$past(cnt_lo)) |-> $stable(cnt_hi));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmp |=> $stable(cmp_val));

    // R8
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !wr_cmp && (cmp_val == XLEN'(cnt_lo)) |=> mtip_o && !armed);

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mtip_o && !wr_cmp |=> mtip_o);

    // R10
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> armed && !mtip_o);

    // R11
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !mtip_o && !wr_cmp |=> !armed && !mtip_o);
endmodule

bind cycle_timer_csr cyc_timer_chk #(
    .WORD_W (WORD_W),
    .XLEN   (XLEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .mtip_o    (mtip_o),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .cmp_val   (cmp_val),
    .armed     (armed)
);

// File: tb/tb_cycle_timer_csr.sv
// Bench for cycle_timer_csr: directed corner cases plus seeded random
// register traffic, checked every cycle against a behavioural model.
module tb_cycle_timer_csr;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned W        = 12;
    localparam int unsigned MAX_CYC  = 150000;
    localparam logic [11:0] A_LO  = 12'hB00;
    localparam logic [11:0] A_HI  = 12'hB80;
    localparam logic [11:0] A_UC  = 12'hC00;
    localparam logic [11:0] A_UT  = 12'hC01;
    localparam logic [11:0] A_UI  = 12'hC02;
    localparam logic [11:0] A_CMP = 12'h7C0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        mtip;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cycle_timer_csr #(.WORD_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .mtip_o    (mtip)
    );

    // Behavioural model built from the requirements.
    logic [W-1:0] m_lo;
    logic [W-1:0] m_hi;
    logic [31:0]  m_cmp;
    logic         m_arm;
    logic         m_tip;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo <= '0; m_hi <= '0; m_cmp <= '0; m_arm <= 1'b0; m_tip <= 1'b0;
        end else begin
            m_lo <= m_lo + 1'b1;
            if (m_lo == {W{1'b1}}) m_hi <= m_hi + 1'b1;
            if (wr_en && wr_addr == A_CMP) begin
                m_cmp <= wr_data; m_arm <= 1'b1; m_tip <= 1'b0;
            end else if (m_arm && m_cmp == {{(32-W){1'b0}}, m_lo}) begin
                m_arm <= 1'b0; m_tip <= 1'b1;
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            A_LO, A_UC, A_UT: return {{(32-W){1'b0}}, m_lo};
            A_HI:             return {{(32-W){1'b0}}, m_hi};
            A_CMP:            return m_cmp;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [11:0] a);
        case (a)
            A_LO, A_HI:       return "R4";
            A_UC, A_UT, A_UI: return "R5";
            A_CMP:            return "R6";
            default:          return "R12";
        endcase
    endfunction

    function automatic logic [11:0] pick_addr(input int unsigned r);
        case (r % 8)
            0: return A_LO;
            1: return A_HI;
            2: return A_UC;
            3: return A_UT;
            4: return A_UI;
            5: return A_CMP;
            6: return 12'h300;
            default: return 12'($urandom);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic cyc(input logic [11:0] ra, input logic we, input logic [11:0] wa,
                       input logic [31:0] wd, input string tag);
        rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        chk((tag == "") ? rd_tag(ra) : tag, rd_data, exp_rd(ra));
        chk((tag == "") ? "R8" : tag, {31'b0, mtip}, {31'b0, m_tip});
    endtask

    task automatic rd(input logic [11:0] ra, input string tag);
        cyc(ra, 1'b0, 12'h000, 32'h0, tag);
    endtask

    logic [31:0] v1;
    logic [31:0] v2;
    logic [31:0] tgt;

    initial begin
        v1 = $urandom(32'h00C0FFEE);
        rst_n = 1'b0;
        // R1: reset state of counters, compare and pending.
        rd(A_LO, "R1");
        rd(A_HI, "R1");
        rd(A_CMP, "R1");
        chk("R1", rd_data, 32'h0);
        chk("R1", {31'b0, mtip}, 32'h0);
        rst_n = 1'b1;

        // R2: consecutive low-word reads differ by one.
        rd(A_LO, "R2");
        v1 = rd_data;
        rd(A_LO, "R2");
        v2 = rd_data;
        chk("R2", v2, v1 + 32'd1);

        // R11: run past a full wrap through zero with comparator never armed.
        for (int i = 0; i < (1 << W) + 16; i++) rd((i % 2) ? A_UT : A_UC, "R11");
        chk("R11", {31'b0, mtip}, 32'h0);

        // R3: high word counted the wrap.
        rd(A_HI, "R3");
        chk("R3", rd_data, 32'd1);

        // R7: writes to counter and alias addresses are ignored.
        cyc(A_LO, 1'b1, A_LO, 32'h0000_0555, "R7");
        cyc(A_HI, 1'b1, A_HI, 32'h0000_0AAA, "R7");
        cyc(A_CMP, 1'b1, A_UC, 32'h1234_5678, "R7");
        chk("R7", rd_data, 32'h0);

        // R6/R8: arm with a target a few cycles ahead.
        tgt = {{(32-W){1'b0}}, m_lo} + 32'd6;
        cyc(A_CMP, 1'b1, A_CMP, tgt, "R10");
        chk("R6", rd_data, tgt);
        for (int i = 0; i < 10; i++) rd(A_LO, "R8");
        chk("R8", {31'b0, mtip}, 32'h1);

        // R9: pending stays set across another match.
        for (int i = 0; i < (1 << W) + 8; i++) rd(A_HI, "R9");
        chk("R9", {31'b0, mtip}, 32'h1);

        // R10: write clears pending; a write landing on the match cycle wins.
        tgt = {{(32-W){1'b0}}, m_lo} + 32'd2;
        cyc(A_CMP, 1'b1, A_CMP, tgt, "R10");
        chk("R10", {31'b0, mtip}, 32'h0);
        rd(A_LO, "R10");
        cyc(A_CMP, 1'b1, A_CMP, 32'hFFFF_0000, "R10");
        chk("R10", {31'b0, mtip}, 32'h0);
        for (int i = 0; i < 8; i++) rd(A_CMP, "R10");
        chk("R10", {31'b0, mtip}, 32'h0);

        // R12: unmapped addresses read zero; R5: instret alias reads zero.
        rd(12'h000, "R12");
        rd(12'h7C1, "R12");
        rd(12'hFFF, "R12");
        rd(A_UI, "R5");
        chk("R5", rd_data, 32'h0);

        // Seeded random traffic.
        for (int i = 0; i < 30000; i++) begin
            logic        we;
            logic [11:0] wa;
            logic [31:0] wd;
            we = ($urandom % 16) == 0;
            wa = (($urandom % 10) < 7) ? A_CMP : pick_addr($urandom);
            wd = ($urandom % 2) ? ({{(32-W){1'b0}}, m_lo} + 32'($urandom % 64)) : $urandom;
            cyc(pick_addr($urandom), we, wa, wd, "");
        end

        // R1: reset in mid-run clears everything again.
        tgt = {{(32-W){1'b0}}, m_lo} + 32'd3;
        cyc(A_LO, 1'b1, A_CMP, tgt, "R10");
        rst_n = 1'b0;
        rd(A_LO, "R1");
        rd(A_CMP, "R1");
        chk("R1", rd_data, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) rd(A_LO, "R11");
        chk("R11", {31'b0, mtip}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule